// File: doc/BRIEF.md
# Dual Up-Counting Watchdog

This block holds two independent watchdog timers behind a small 32-bit register port. Both timers advance on a slow external tick, one pulse per 10 ms time unit, which an outside prescaler supplies. Each timer counts up from zero and compares its count against a programmed expiry value. Once the count reaches that value, the count stops and the timer takes its own expiry action. Software keeps a timer from expiring by writing its register, because any write sets the count back to zero.

Timer A (word offset 0x0) can be set up to request a system reset when it expires. The request is a single-cycle pulse. Timer B (word offset 0x4) counts only while its enable bit is set. When it expires it raises a protection flag. That flag tells an external switch to drop CPU-bound packets and to stop flow control on all ports. The flag stays high until software writes timer B again.

Each timer is driven by a four-state machine:
- IDLE: the timer is disarmed. It enters this state after reset, after a write with a set value of zero, or, for timer B, after a write with the enable bit clear.
- COUNT: the timer is armed. It enters this state after a write with a non-zero set value and, for timer B, the enable bit set.
- FIRE: COUNT moves to FIRE on a tick that brings the count equal to the set value. FIRE lasts exactly one cycle.
- HOLD: FIRE always moves to HOLD. HOLD stays put until the next write.

A write to a timer moves that timer to IDLE or COUNT from any state.

Top module: `wdog_duo`

## Requirements
- R1: Register layout, identical for both timers:
  - Bit 31 is the control bit.
  - Bits 30..16 hold the 15-bit set value.
  - Bit 15 reads as 0.
  - Bits 14..0 hold the running count.
  - Address bit 2 selects the timer: 0 for timer A, 1 for timer B. Address bits 1..0 are ignored.
  - A write stores bits 31 and 30..16. The written values of bits 15..0 are ignored.
  - Reads return the selected register combinationally.
- R2: While armed and not expired, a timer's count rises by exactly one on each cycle in which `tick_10ms` is high. The count does not change in cycles without a tick.
- R3: A write to a timer clears its count to zero and loads the new control bit and set value. If a tick arrives in the same cycle as the write, the write wins and the count reads 0 afterwards.
- R4: A timer expires when its count equals its set value. After that the count holds at the set value and further ticks neither change it nor wrap it.
- R5: A set value of zero disarms a timer. Its count stays 0 and it never expires.
- R6: Timer A with bit 31 = 1 drives `rst_req` high for exactly one cycle, starting after the clock edge at which the count reaches the set value. With bit 31 = 0 the timer still expires and holds, but `rst_req` stays low.
- R7: Timer B counts only while its bit 31 is 1. With bit 31 = 0 its count stays 0 and `prot_flag` stays low.
- R8: `prot_flag` rises after the clock edge at which enabled timer B reaches its set value. It stays high until the next write to timer B.
- R9: After reset both registers read 0, and `rst_req` and `prot_flag` are low.
- R10: A write to one timer leaves the other timer's control bit, set value and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_10ms | input | 1 | One-cycle pulse per 10 ms time unit |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for `bus_sel` |
| bus_addr | input | ADDR_W (3) | Byte address; bit 2 picks the timer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed timer |
| rst_req | output | 1 | One-cycle reset request from timer A |
| prot_flag | output | 1 | Traffic-protection flag from timer B |

## Verification
The tick and a software write can land in the same cycle, and so can the write and the expiring tick itself. The defined outcome is that the write wins: the count reads zero, the timer re-arms, and no expiry follows. The bench forces this collision directly on timer B while its flag is high. It also produces the collision by chance during a long stretch of random ticks and writes with small set values. A behavioural model evaluated on every clock judges each cycle's read data, reset pulse and protection flag.

// File: rtl/wdog_duo_pkg.sv
package wdog_duo_pkg;

    localparam int WORD_W   = 32;
    localparam int CNT_W    = 15;
    localparam int SET_LSB  = 16;
    localparam int CTRL_BIT = 31;
    localparam int NUM_TMR  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FIRE,
        ST_HOLD
    } wd_state_e;

endpackage

// File: rtl/wdog_duo_unit.sv
module wdog_duo_unit
    import wdog_duo_pkg::*;
#(
    parameter int CW       = CNT_W,
    parameter bit NEEDS_EN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic          load_ctrl,
    input  logic [CW-1:0] load_set,
    output logic          ctrl_q,
    output logic [CW-1:0] set_q,
    output logic [CW-1:0] cnt_q,
    output logic          fire,
    output logic          expired
);

    wd_state_e     state_q, state_d;
    logic          arm_ok;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + CW'(1);

    generate
        if (NEEDS_EN) begin : g_gated
            assign arm_ok = (load_set != '0) && load_ctrl;
        end else begin : g_free
            assign arm_ok = (load_set != '0);
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = arm_ok ? ST_COUNT : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_COUNT: if (tick && (cnt_inc == set_q)) state_d = ST_FIRE;
                ST_FIRE:  state_d = ST_HOLD;
                ST_HOLD:  state_d = ST_HOLD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctrl_q  <= 1'b0;
            set_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                ctrl_q <= load_ctrl;
                set_q  <= load_set;
                cnt_q  <= '0;
            end else if (state_q == ST_COUNT && tick) begin
                cnt_q <= cnt_inc;
            end
        end
    end

    always_comb begin
        fire    = 1'b0;
        expired = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_COUNT: ;
            ST_FIRE:  begin fire = 1'b1; expired = 1'b1; end
            ST_HOLD:  expired = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/wdog_duo_regif.sv
module wdog_duo_regif
    import wdog_duo_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int NUM    = NUM_TMR,
    parameter int CW     = CNT_W
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ctrl_q  [NUM],
    input  logic [CW-1:0]     set_q   [NUM],
    input  logic [CW-1:0]     cnt_q   [NUM],
    output logic              wr_hit  [NUM],
    output logic [WORD_W-1:0] rdata
);

    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

    logic [IDX_W-1:0] idx;
    assign idx = bus_addr[2 +: IDX_W];

    generate
        for (genvar i = 0; i < NUM; i++) begin : g_hit
            assign wr_hit[i] = bus_sel && bus_we && (idx == IDX_W'(i));
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM; i++) begin
            if (idx == IDX_W'(i)) begin
                rdata[CTRL_BIT]              = ctrl_q[i];
                rdata[SET_LSB +: CW]         = set_q[i];
                rdata[CW-1:0]                = cnt_q[i];
            end
        end
    end

endmodule

// File: rtl/wdog_duo.sv
module wdog_duo
    import wdog_duo_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_10ms,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req,
    output logic              prot_flag
);

    logic             ctrl_q  [NUM_TMR];
    logic [CNT_W-1:0] set_q   [NUM_TMR];
    logic [CNT_W-1:0] cnt_q   [NUM_TMR];
    logic             wr_hit  [NUM_TMR];
    logic             fire    [NUM_TMR];
    logic             expired [NUM_TMR];

    wdog_duo_regif #(.ADDR_W(ADDR_W), .NUM(NUM_TMR), .CW(CNT_W)) u_regif (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .ctrl_q   (ctrl_q),
        .set_q    (set_q),
        .cnt_q    (cnt_q),
        .wr_hit   (wr_hit),
        .rdata    (bus_rdata)
    );

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            wdog_duo_unit #(.CW(CNT_W), .NEEDS_EN(i == 1)) u_unit (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick_10ms),
                .load      (wr_hit[i]),
                .load_ctrl (bus_wdata[CTRL_BIT]),
                .load_set  (bus_wdata[SET_LSB +: CNT_W]),
                .ctrl_q    (ctrl_q[i]),
                .set_q     (set_q[i]),
                .cnt_q     (cnt_q[i]),
                .fire      (fire[i]),
                .expired   (expired[i])
            );
        end
    endgenerate

    assign rst_req   = fire[0] && ctrl_q[0];
    assign prot_flag = expired[1];

endmodule

// File: rtl/wdog_duo_chk.sv
module wdog_duo_chk #(
    parameter int ADDR_W = 3,
    parameter int CW     = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rst_req,
    input logic              prot_flag,
    input logic [CW-1:0]     cnt_a,
    input logic [CW-1:0]     set_a,
    input logic [CW-1:0]     cnt_b,
    input logic [CW-1:0]     set_b,
    input logic              ctrl_b
);

    logic wr_a, wr_b;
    assign wr_a = bus_sel && bus_we && !bus_addr[2];
    assign wr_b = bus_sel && bus_we &&  bus_addr[2];

    p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_clear_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> (cnt_a == '0));

    p_clear_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> (cnt_b == '0));

    p_step_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_a |=> (cnt_a == $past(cnt_a)) || (cnt_a == $past(cnt_a) + CW'(1)));

    p_step_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_b |=> (cnt_b == $past(cnt_b)) || (cnt_b == $past(cnt_b) + CW'(1)));

    p_no_wrap_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_a <= set_a);

    p_no_wrap_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_b <= set_b);

    p_zero_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_a == '0) |-> (cnt_a == '0) && !rst_req);

    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_b |-> (cnt_b == '0) && !prot_flag);

    p_prot_at_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_flag |-> ctrl_b && (set_b != '0) && (cnt_b == set_b));

endmodule

bind wdog_duo wdog_duo_chk #(.ADDR_W(ADDR_W), .CW(wdog_duo_pkg::CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .rst_req   (rst_req),
    .prot_flag (prot_flag),
    .cnt_a     (cnt_q[0]),
    .set_a     (set_q[0]),
    .cnt_b     (cnt_q[1]),
    .set_b     (set_q[1]),
    .ctrl_b    (ctrl_q[1])
);

// File: tb/tb_wdog_duo.sv
module tb_wdog_duo;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 3;
    localparam int WD_LIMIT   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              sel = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rst_req;
    logic              prot;

    int total = 0;
    int bad   = 0;
    bit active = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_duo #(.ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_10ms (tick),
        .bus_sel   (sel),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .rst_req   (rst_req),
        .prot_flag (prot)
    );

    // Behavioural reference model
    int m_ctrl [2];
    int m_set  [2];
    int m_cnt  [2];
    bit m_exp  [2];
    bit m_fire [2];

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                m_ctrl[i] = 0; m_set[i] = 0; m_cnt[i] = 0;
                m_exp[i] = 0;  m_fire[i] = 0;
            end else if (sel && we && (int'(addr[2]) == i)) begin
                m_ctrl[i] = int'(wdata[31]);
                m_set[i]  = int'(wdata[30:16]);
                m_cnt[i]  = 0;
                m_exp[i]  = 0;
                m_fire[i] = 0;
            end else begin
                m_fire[i] = 0;
                if (!m_exp[i] && m_set[i] != 0 && (i == 0 || m_ctrl[i] != 0) && tick) begin
                    m_cnt[i] = m_cnt[i] + 1;
                    if (m_cnt[i] == m_set[i]) begin
                        m_exp[i]  = 1;
                        m_fire[i] = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_word(input int i);
        logic [31:0] w;
        w = '0;
        w[31]    = m_ctrl[i][0];
        w[30:16] = m_set[i][14:0];
        w[14:0]  = m_cnt[i][14:0];
        return w;
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (active && !done) begin
            chk(rst_req == (m_fire[0] && m_ctrl[0] != 0), "R6 rst_req",
                {31'b0, rst_req}, {31'b0, m_fire[0] && m_ctrl[0] != 0});
            chk(prot == m_exp[1], "R8 prot_flag", {31'b0, prot}, {31'b0, m_exp[1]});
            chk(rdata == model_word(int'(addr[2])), "R1 R2 readback", rdata, model_word(int'(addr[2])));
        end
    end

    task automatic step(input bit t, input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        tick = t; sel = w; we = w; addr = a; wdata = d;
    endtask

    task automatic ticks(input int n, input logic [ADDR_W-1:0] a);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, 1'b0, a, 32'h0);
        @(negedge clk);
        chk(rdata == exp, tag, rdata, exp);
    endtask

    function automatic logic [31:0] wv(input bit c, input int s);
        return {c, 15'(s), 16'h0};
    endfunction

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WD_LIMIT);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        active = 1;

        // R9: reset state
        peek(3'd0, 32'h0, "R9 timer A after reset");
        peek(3'd4, 32'h0, "R9 timer B after reset");
        chk(!rst_req && !prot, "R9 outputs low", {30'b0, rst_req, prot}, 32'h0);

        // R1/R2/R4/R6: timer A with reset action, set 3; junk in low bits ignored
        step(1'b0, 1'b1, 3'd0, wv(1, 3) | 32'h0000_FFFF);
        peek(3'd0, 32'h8003_0000, "R1 written low bits ignored");
        ticks(2, 3'd0);
        peek(3'd0, 32'h8003_0002, "R2 two ticks");
        step(1'b1, 1'b0, 3'd0, 32'h0);
        peek(3'd0, 32'h8003_0003, "R4 reached set");
        chk(rst_req == 1'b1, "R6 pulse after expiry", {31'b0, rst_req}, 32'h1);
        ticks(3, 3'd0);
        peek(3'd0, 32'h8003_0003, "R4 holds without wrap");
        chk(rst_req == 1'b0, "R6 pulse single", {31'b0, rst_req}, 32'h0);

        // R5: zero set value disarms
        step(1'b0, 1'b1, 3'd0, wv(1, 0));
        ticks(4, 3'd0);
        peek(3'd0, 32'h8000_0000, "R5 zero set never counts");

        // R6: no reset action when bit 31 clear
        step(1'b0, 1'b1, 3'd0, wv(0, 2));
        ticks(2, 3'd0);
        peek(3'd0, 32'h0002_0002, "R6 expiry without request");
        chk(rst_req == 1'b0, "R6 no pulse when disabled", {31'b0, rst_req}, 32'h0);

        // R7: timer B disabled; address low bits ignored (R1)
        step(1'b0, 1'b1, 3'd7, wv(0, 2));
        ticks(3, 3'd4);
        peek(3'd4, 32'h0002_0000, "R7 disabled B stays zero");
        chk(prot == 1'b0, "R7 no flag when disabled", {31'b0, prot}, 32'h0);

        // R8: timer B enabled
        step(1'b0, 1'b1, 3'd4, wv(1, 2));
        ticks(2, 3'd4);
        peek(3'd4, 32'h8002_0002, "R8 B reached set");
        chk(prot == 1'b1, "R8 flag raised", {31'b0, prot}, 32'h1);
        peek(3'd0, 32'h0002_0002, "R10 A untouched by B");
        ticks(3, 3'd4);
        chk(prot == 1'b1, "R8 flag sticky", {31'b0, prot}, 32'h1);

        // R3: write and tick in the same cycle, write wins
        step(1'b1, 1'b1, 3'd4, wv(1, 2));
        peek(3'd4, 32'h8002_0000, "R3 write beats tick");
        chk(prot == 1'b0, "R3 R8 flag cleared by write", {31'b0, prot}, 32'h0);

        // R10: write to A keeps B count
        ticks(1, 3'd4);
        step(1'b0, 1'b1, 3'd0, wv(1, 5));
        peek(3'd4, 32'h8002_0001, "R10 B untouched by A");
        peek(3'd0, 32'h8005_0000, "R10 A reloaded");

        // Random phase, model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 3) == 0,
                 ($urandom % 40) == 0,
                 ADDR_W'($urandom % 8),
                 {1'($urandom), 15'($urandom % 6), 16'($urandom)});
        end
        step(1'b0, 1'b0, 3'd0, 32'h0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule